// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

The block groups two or three down-counting timer channels behind one 48-byte register window. A register port carries byte addresses; the decoder steers each access to a shared run-control word, to an optional one-bit output-control word, or to the three-word register set of one channel. Each channel holds a reload value, a live count and a control word. The control word selects the prescaler ratio, enables the channel interrupt and holds the underflow flag.

Software loads a reload value and a start count, selects a prescaler ratio and then sets the channel's bit in the run-control word. While its bit is set, a channel divides the clock by the selected ratio and decrements its count once per prescaled tick. A tick at a count of zero reloads the count and raises the underflow flag. Clearing the run bit freezes both the count and the prescaler phase. Each channel drives its own interrupt line. One parameter chooses between the two-channel build and the three-channel build, and only the three-channel build has the output-control word.

Top module: `tmu_unit`

## Requirements
- R1: After reset the run-control word reads 0, so every channel is stopped. Every reload and count word reads 0xFFFFFFFF, every control word and the output-control word read 0, and `err` and all `irq` lines are low.
- R2: The map is word based and ignores `addr[1:0]`. Output-control is at 0x00 (three-channel build only) and run-control at 0x04. The channels start at 0x08, 0x14 and 0x20 (the third in the three-channel build only). Within a channel, +0 is reload, +4 is count and +8 is control. Read data appears on `rdata` one cycle after `rd_en` and holds until the next read.
- R3: The run-control word stores all 32 written bits and reads them back unchanged. Bit i runs channel i.
- R4: A running channel with prescaler select s (0 to 4) ticks once every 4·4^s clocks. A tick decrements a nonzero count. A tick at count 0 loads the reload value and sets the underflow flag.
- R5: Clearing a run bit holds the channel's count and prescaler phase. Setting the bit again resumes counting from that phase.
- R6: Control word fields: bits [2:0] are the prescaler select, bit 5 enables the interrupt and bit 8 is the underflow flag. Other bits read 0. Writing 0 to bit 8 clears the flag and writing 1 leaves it unchanged. A control write restarts the prescaler phase.
- R7: A control write whose select field is 5, 6 or 7 changes nothing in the channel and pulses `err`.
- R8: `irq[i]` is high exactly while channel i has both its underflow flag and its interrupt enable set.
- R9: The output-control word keeps only bit 0 of a write.
- R10: An access to an address that maps to no register (0x2C to 0x3F in the three-channel build; 0x00 to 0x03 and 0x20 to 0x3F in the two-channel build) reads 0, changes no state and pulses `err` for one cycle, one cycle after the access.
- R11: In the two-channel build, a run-control write with bit 2 set pulses `err`. The write is still stored and still acts on bits 0 and 1.
- R12: A count write wins over a tick in the same cycle. A reload write does not change the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 6 | Byte address inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| err | output | 1 | One-cycle pulse for a bad access |
| irq | output | NCH | Per-channel interrupt, NCH is 3 or 2 |

## Verification
Read data and the error pulse are registered, so both are due on the clock edge that samples the strobe. The bench reads them at the falling edge that follows that edge. A channel changes its count on every edge while its run bit is set, including the edge that clears the bit. The bench therefore brackets each run between a start write and a stop write and counts the edges in between. From that count it computes the expected number of ticks, floor(edges / ratio), and only then reads the count and the flag back. For the same-edge conflict between a count write and a tick, the bench times the write to land exactly on the fourth running edge.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 6;
    localparam int WINDOW_BYTES = 'h30;
    localparam int RUN_BYTE     = 'h04;
    localparam int CH_FIRST     = 'h08;
    localparam int CH_STRIDE    = 'h0C;
    localparam int CH_WORDS     = 3;
    localparam int SEL_W        = 3;
    localparam int SEL_MAX      = 4;
    localparam int CTL_IE_BIT   = 5;
    localparam int CTL_FLAG_BIT = 8;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_OUTCTL,
        TGT_RUN,
        TGT_CHAN
    } target_e;

    typedef enum logic [1:0] {
        CREG_RELOAD,
        CREG_COUNT,
        CREG_CTRL,
        CREG_NONE
    } chreg_e;

    function automatic int chan_base(input int idx);
        return CH_FIRST + CH_STRIDE * idx;
    endfunction
endpackage

// File: rtl/tmu_decode.sv
module tmu_decode
    import tmu_pkg::*;
#(
    parameter int NCH     = 3,
    parameter bit HAS_OUT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output target_e           target,
    output logic [1:0]        chan,
    output chreg_e            creg
);
    always_comb begin
        target = TGT_NONE;
        chan   = '0;
        creg   = CREG_NONE;
        if (HAS_OUT && int'(addr) < RUN_BYTE) begin
            target = TGT_OUTCTL;
        end else if (int'(addr) >= RUN_BYTE && int'(addr) < CH_FIRST) begin
            target = TGT_RUN;
        end
        for (int i = 0; i < NCH; i++) begin
            if (int'(addr) >= chan_base(i) &&
                int'(addr) < chan_base(i) + 4 * CH_WORDS &&
                int'(addr) < WINDOW_BYTES) begin
                target = TGT_CHAN;
                chan   = 2'(i);
                creg   = chreg_e'(2'((int'(addr) - chan_base(i)) >> 2));
            end
        end
    end
endmodule

// File: rtl/tmu_prescaler.sv
module tmu_prescaler
    import tmu_pkg::*;
#(
    parameter int BASE_LOG2 = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = BASE_LOG2 + STEP_LOG2 * SEL_MAX;

    logic [PRE_W-1:0] phase_d, phase_q;
    logic [PRE_W-1:0] limit;
    int               sel_c;

    always_comb begin
        sel_c = (int'(sel) > SEL_MAX) ? SEL_MAX : int'(sel);
        limit = PRE_W'((1 << (BASE_LOG2 + STEP_LOG2 * sel_c)) - 1);
        tick  = run && (phase_q >= limit);
        phase_d = phase_q;
        if (restart || tick) begin
            phase_d = '0;
        end else if (run) begin
            phase_d = phase_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
    import tmu_pkg::*;
#(
    parameter int BASE_LOG2 = 2,
    parameter int STEP_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_en,
    input  chreg_e            creg,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] count,
    output logic              irq,
    output logic              cfg_err
);
    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] count;
        logic [SEL_W-1:0]  sel;
        logic              ie;
        logic              flag;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      tick;
    logic      ctl_wr;
    logic      sel_ok;

    assign ctl_wr = wr_en && (creg == CREG_CTRL);
    assign sel_ok = int'(wdata[SEL_W-1:0]) <= SEL_MAX;

    tmu_prescaler #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (ctl_wr && sel_ok),
        .sel     (s_q.sel),
        .tick    (tick)
    );

    always_comb begin
        s_d = s_q;
        if (tick) begin
            if (s_q.count == '0) begin
                s_d.count = s_q.reload;
                s_d.flag  = 1'b1;
            end else begin
                s_d.count = s_q.count - DATA_W'(1);
            end
        end
        if (wr_en) begin
            case (creg)
                CREG_RELOAD: s_d.reload = wdata;
                CREG_COUNT:  s_d.count  = wdata;
                CREG_CTRL: begin
                    if (sel_ok) begin
                        s_d.sel = wdata[SEL_W-1:0];
                        s_d.ie  = wdata[CTL_IE_BIT];
                        if (!wdata[CTL_FLAG_BIT]) s_d.flag = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (creg)
            CREG_RELOAD: rd_data = s_q.reload;
            CREG_COUNT:  rd_data = s_q.count;
            CREG_CTRL: begin
                rd_data[SEL_W-1:0]    = s_q.sel;
                rd_data[CTL_IE_BIT]   = s_q.ie;
                rd_data[CTL_FLAG_BIT] = s_q.flag;
            end
            default: rd_data = '0;
        endcase
    end

    assign count   = s_q.count;
    assign irq     = s_q.flag && s_q.ie;
    assign cfg_err = ctl_wr && !sel_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.reload <= '1;
            s_q.count  <= '1;
            s_q.sel    <= '0;
            s_q.ie     <= 1'b0;
            s_q.flag   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tmu_unit.sv
module tmu_unit
    import tmu_pkg::*;
#(
    parameter bit THREE_CH  = 1'b1,
    parameter int BASE_LOG2 = 2,
    parameter int STEP_LOG2 = 2,
    localparam int NCH      = THREE_CH ? 3 : 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [NCH-1:0]    irq
);
    typedef struct packed {
        logic [DATA_W-1:0] run;
        logic              outctl;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    target_e dec_target;
    logic [1:0] dec_chan;
    chreg_e dec_creg;

    logic [NCH-1:0][DATA_W-1:0] ch_rd;
    logic [NCH-1:0][DATA_W-1:0] ch_count;
    logic [NCH-1:0]             ch_cfg_err;
    logic [DATA_W-1:0]          run_bits;

    assign run_bits = st_q.run;

    tmu_decode #(
        .NCH     (NCH),
        .HAS_OUT (THREE_CH)
    ) u_dec (
        .addr   (addr),
        .target (dec_target),
        .chan   (dec_chan),
        .creg   (dec_creg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmu_channel #(
            .BASE_LOG2 (BASE_LOG2),
            .STEP_LOG2 (STEP_LOG2)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_bits[g]),
            .wr_en   (wr_en && dec_target == TGT_CHAN && dec_chan == 2'(g)),
            .creg    (dec_creg),
            .wdata   (wdata),
            .rd_data (ch_rd[g]),
            .count   (ch_count[g]),
            .irq     (irq[g]),
            .cfg_err (ch_cfg_err[g])
        );
    end

    logic [DATA_W-1:0] read_val;
    logic              mapped;
    logic              bad_run_wr;

    always_comb begin
        read_val = '0;
        case (dec_target)
            TGT_OUTCTL: read_val = DATA_W'(st_q.outctl);
            TGT_RUN:    read_val = st_q.run;
            TGT_CHAN: begin
                for (int i = 0; i < NCH; i++) begin
                    if (dec_chan == 2'(i)) read_val = ch_rd[i];
                end
            end
            default: read_val = '0;
        endcase
    end

    always_comb begin
        mapped     = (dec_target != TGT_NONE) &&
                     !(dec_target == TGT_CHAN && dec_creg == CREG_NONE);
        bad_run_wr = wr_en && (dec_target == TGT_RUN) && !THREE_CH && wdata[2];

        st_d     = st_q;
        st_d.err = ((wr_en || rd_en) && !mapped) || (|ch_cfg_err) || bad_run_wr;
        if (rd_en) begin
            st_d.rdata = mapped ? read_val : '0;
        end
        if (wr_en) begin
            if (dec_target == TGT_OUTCTL) st_d.outctl = wdata[0];
            if (dec_target == TGT_RUN)    st_d.run    = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run    <= '0;
            st_q.outctl <= 1'b0;
            st_q.err    <= 1'b0;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign err   = st_q.err;
endmodule

// File: rtl/tmu_unit_chk.sv
module tmu_unit_chk
    import tmu_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic                       rd_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [DATA_W-1:0]          wdata,
    input logic                       err,
    input logic [NCH-1:0]             irq,
    input logic [DATA_W-1:0]          run_bits,
    input logic [NCH-1:0][DATA_W-1:0] ch_count
);
    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_en || rd_en)); // R10

    AST_OUT_OF_WINDOW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && int'(addr) >= WINDOW_BYTES) |=> err); // R10

    AST_RUN_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[5:2] == 4'd1) |=> (run_bits == $past(wdata))); // R3

    AST_TWO_CH_BIT2_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (NCH == 2 && wr_en && addr[5:2] == 4'd1 && wdata[2]) |=> err); // R11

    for (genvar i = 0; i < NCH; i++) begin : g_ch_chk
        AST_PAUSED_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_bits[i] && !wr_en) |=> $stable(ch_count[i])); // R5

        AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(run_bits[i] || wr_en)); // R8
    end
endmodule

bind tmu_unit tmu_unit_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .err      (err),
    .irq      (irq),
    .run_bits (run_bits),
    .ch_count (ch_count)
);

// File: tb/tmu_unit_test.sv
`timescale 1ns/1ps
module tmu_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_a = 1'b0, rd_a = 1'b0, wr_b = 1'b0, rd_b = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        err_a, err_b;
    logic [2:0]  irq_a;
    logic [1:0]  irq_b;

    int          checks = 0;
    int          failures = 0;
    bit          use_b = 1'b0;
    logic [31:0] got;
    logic        got_err;

    always #4 clk = ~clk;

    tmu_unit #(.THREE_CH(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .rd_en(rd_a), .addr(addr),
        .wdata(wdata), .rdata(rdata_a), .err(err_a), .irq(irq_a)
    );

    tmu_unit #(.THREE_CH(1'b0)) uut2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .rd_en(rd_b), .addr(addr),
        .wdata(wdata), .rdata(rdata_b), .err(err_b), .irq(irq_b)
    );

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access per clock edge; entered and left at a falling edge
    task automatic op(input bit wr, input logic [5:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_a  = wr && !use_b;
        rd_a  = !wr && !use_b;
        wr_b  = wr && use_b;
        rd_b  = !wr && use_b;
        @(negedge clk);
        got     = use_b ? rdata_b : rdata_a;
        got_err = use_b ? err_b : err_a;
        wr_a = 1'b0; rd_a = 1'b0; wr_b = 1'b0; rd_b = 1'b0;
    endtask

    task automatic wr32(input logic [5:0] a, input logic [31:0] d);
        op(1'b1, a, d);
    endtask

    task automatic rd32(input logic [5:0] a);
        op(1'b0, a, 32'h0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_count(input longint c, input longint r, input longint t);
        longint t2;
        if (t <= c) return 32'(c - t);
        t2 = t - (c + 1);
        return 32'(r - (t2 % (r + 1)));
    endfunction

    function automatic logic [5:0] cbase(input int ch);
        return 6'(8 + 12 * ch);
    endfunction

    initial begin
        int waits [12] = '{0, 2, 3, 6, 7, 11, 15, 22, 31, 46, 63, 95};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, three-channel build
        check("R1 irq", 32'(irq_a), 32'h0);
        rd32(6'h04); check("R1 run word", got, 32'h0);
        rd32(6'h00); check("R1 outctl", got, 32'h0);
        for (int ch = 0; ch < 3; ch++) begin
            rd32(cbase(ch));     check("R1 reload", got, 32'hFFFF_FFFF);
            rd32(cbase(ch) + 4); check("R1 count", got, 32'hFFFF_FFFF);
            rd32(cbase(ch) + 8); check("R1 control", got, 32'h0);
        end

        // R10 R2 sweep of every address: error flag and zero data
        for (int a = 0; a < 64; a++) begin
            bit mapped;
            mapped = (a < 'h2C);
            rd32(6'(a));
            check("R10 err per address", 32'(got_err), 32'(!mapped));
            if (!mapped) check("R10 unmapped read zero", got, 32'h0);
        end

        // R2 distinct reload per channel, low address bits ignored
        for (int ch = 0; ch < 3; ch++) wr32(cbase(ch), 32'h1000_0000 + 32'(ch * 17));
        for (int ch = 0; ch < 3; ch++) begin
            rd32(cbase(ch) + 6'(ch)); check("R2 reload readback", got, 32'h1000_0000 + 32'(ch * 17));
        end

        // R3 full run word echoes, run bits clear
        wr32(6'h04, 32'hA5A5_0000);
        rd32(6'h04); check("R3 run word echo", got, 32'hA5A5_0000);
        wr32(6'h04, 32'h0);

        // R4 R8 counting sweep over channel, ratio and run length
        for (int ch = 0; ch < 3; ch++) begin
            for (int s = 0; s < 2; s++) begin
                foreach (waits[k]) begin
                    longint c, r, t;
                    int div;
                    bit fl;
                    c = 2 + s; r = 3 + ch;
                    div = 4 << (2 * s);
                    wr32(cbase(ch) + 8, 32'(s) | 32'h20);
                    wr32(cbase(ch), 32'(r));
                    wr32(cbase(ch) + 4, 32'(c));
                    wr32(6'h04, 32'(1 << ch));
                    idle(waits[k]);
                    wr32(6'h04, 32'h0);
                    t = longint'((waits[k] + 1) / div);
                    fl = (t >= c + 1);
                    rd32(cbase(ch) + 4); check("R4 count after run", got, exp_count(c, r, t));
                    rd32(cbase(ch) + 8);
                    check("R6 control readback", got, (32'(fl) << 8) | 32'h20 | 32'(s));
                    check("R8 irq follows flag", 32'(irq_a[ch]), 32'(fl));
                end
            end
        end

        // R5 pause keeps count and prescaler phase
        wr32(6'h14 + 8, 32'h0);
        wr32(6'h14, 32'd9);
        wr32(6'h18, 32'd20);
        wr32(6'h04, 32'h2);
        idle(6);
        wr32(6'h04, 32'h0);
        idle(7);
        rd32(6'h18); check("R5 held count", got, 32'd19);
        wr32(6'h04, 32'h2);
        wr32(6'h04, 32'h0);
        rd32(6'h18); check("R5 phase kept across pause", got, 32'd18);

        // R12 count write lands on the tick edge; reload write leaves count
        wr32(6'h08 + 8, 32'h20);
        wr32(6'h0C, 32'd50);
        wr32(6'h04, 32'h1);
        idle(3);
        wr32(6'h0C, 32'd7);
        wr32(6'h04, 32'h0);
        rd32(6'h0C); check("R12 count write beats tick", got, 32'd7);
        wr32(6'h08, 32'd99);
        rd32(6'h0C); check("R12 reload write keeps count", got, 32'd7);

        // R7 reserved select values ignored with error
        wr32(6'h10, 32'h25); check("R7 err sel5", 32'(got_err), 32'h1);
        wr32(6'h10, 32'h07); check("R7 err sel7", 32'(got_err), 32'h1);
        rd32(6'h10); check("R7 control unchanged", got, 32'h20);
        wr32(6'h10, 32'h24); check("R7 sel4 accepted", 32'(got_err), 32'h0);
        rd32(6'h10); check("R7 sel4 stored", got, 32'h24);

        // R6 R8 flag handling on channel 2
        wr32(6'h28, 32'h20);
        wr32(6'h20, 32'd5);
        wr32(6'h24, 32'd0);
        wr32(6'h04, 32'h4);
        idle(3);
        wr32(6'h04, 32'h0);
        rd32(6'h24); check("R4 underflow reload", got, 32'd5);
        check("R8 irq on underflow", 32'(irq_a[2]), 32'h1);
        wr32(6'h28, 32'h120);
        rd32(6'h28); check("R6 write 1 keeps flag", got, 32'h120);
        wr32(6'h28, 32'h0000_FFDC);
        rd32(6'h28); check("R6 other bits read 0", got, 32'h104);
        check("R8 irq masked", 32'(irq_a[2]), 32'h0);
        wr32(6'h28, 32'h20);
        rd32(6'h28); check("R6 write 0 clears flag", got, 32'h20);
        check("R8 irq after clear", 32'(irq_a[2]), 32'h0);

        // R9 output-control keeps bit 0
        wr32(6'h00, 32'hFFFF_FFFF);
        rd32(6'h00); check("R9 bit0 set", got, 32'h1);
        wr32(6'h00, 32'hFFFF_FFFE);
        rd32(6'h00); check("R9 bit0 clear", got, 32'h0);

        // R10 unmapped write has no effect
        wr32(6'h2C, 32'h1234); check("R10 write err", 32'(got_err), 32'h1);
        wr32(6'h3C, 32'h1234); check("R10 write err high", 32'(got_err), 32'h1);
        rd32(6'h24); check("R10 no state change", got, 32'd5);

        // two-channel build
        use_b = 1'b1;
        rd32(6'h04); check("R1 two-ch run word", got, 32'h0);
        check("R1 two-ch irq", 32'(irq_b), 32'h0);
        rd32(6'h00); check("R10 two-ch 0x00 err", 32'(got_err), 32'h1);
        check("R10 two-ch 0x00 data", got, 32'h0);
        rd32(6'h20); check("R10 two-ch 0x20 err", 32'(got_err), 32'h1);
        wr32(6'h00, 32'h1); check("R10 two-ch outctl write err", 32'(got_err), 32'h1);
        wr32(6'h14 + 8, 32'h0);
        wr32(6'h18, 32'd10);
        wr32(6'h04, 32'h7); check("R11 bit2 err", 32'(got_err), 32'h1);
        idle(7);
        wr32(6'h04, 32'h0); check("R11 clear no err", 32'(got_err), 32'h0);
        rd32(6'h04); check("R11 run word stored", got, 32'h0);
        rd32(6'h18); check("R11 channel 1 ran", got, 32'd8);
        rd32(6'h0C); check("R11 channel 0 ran", got, 32'hFFFF_FFFD);
        wr32(6'h04, 32'h3); check("R11 bits0-1 no err", 32'(got_err), 32'h0);
        wr32(6'h04, 32'h0);

        summary();
        $finish;
    end
endmodule